// File: doc/BRIEF.md
# Serial Flash Boot Loader with Retry and Fallback

This block loads a configuration image from an external serial flash. It acts as the bus master on a four-wire SPI bus and starts reading at a chosen address. It reads a short header first and checks it. If the header is accepted, the block forwards the payload bytes one at a time to a downstream configuration sink.

When the header is rejected, the block ends the transaction and tries again. The new start address comes from a field inside the rejected image, so images in flash form a chain that should end in a known-good fallback image. If every allowed attempt is rejected, the block stops using flash and streams a built-in image instead. The opcode for the read command is chosen by an input that states whether the serial clock runs fast.

A load starts by itself when reset is released. A falling edge on the reload input starts a new load at any time, as often as needed.

Top module: `flash_boot_loader`

## Requirements
- R1: Each flash transaction begins with opcode 0x03 when `fast_i` is low. When `fast_i` is high it begins with opcode 0x0B, and one dummy byte comes after the address. The address is sent as 24 bits, most significant bit first. The first transaction of a load uses `start_addr_i`.
- R2: The bus uses mode 0. SCLK idles low. MOSI changes after a falling edge. MISO is sampled on the rising edge. Chip select stays low for the whole transaction whenever SCLK is high.
- R3: The image header is 8 bytes: bytes 0-2 hold the next address (MSB first), bytes 3-6 hold the device ID (MSB first), and byte 7 holds the header code. An image is accepted when the ID equals `DEV_ID` (0x1A2B3C4D) and the code equals `HDR_CODE` (0xC3). After acceptance, the `PAYLOAD_LEN` (4) bytes after the header appear in order on `byte_o`, one `byte_vld_o` pulse per byte.
- R4: `err_code_o` shows the cause of the most recent rejection in the current load: 0 means none, 1 means ID mismatch, 2 means header code mismatch. When both fields are wrong, the code is 1.
- R5: After a rejection, chip select goes high. The next attempt reads at the next-address field of the rejected image, and `img_idx_o` goes up by one.
- R6: After `MAX_TRY` (3) rejected attempts, the block streams the internal image instead. The internal image has `PAYLOAD_LEN` bytes with values `INT_SEED`+k (`INT_SEED` = 0xA5). In this case `img_idx_o` equals `MAX_TRY` and `err_o` is high.
- R7: `done_o` goes high only after the last payload byte of an accepted or internal image. It then stays high until the next load starts. `err_o` is never high without `done_o`.
- R8: A falling edge on `reload_n_i` restarts the load from `start_addr_i` and `fast_i`, even in the middle of a load. The number of restarts is unlimited.
- R9: A load starts by itself after reset. `ready_o` is low while a load is in progress and high once it has finished. While `ready_o` is high, chip select is high and SCLK is low.
- R10: During reset, chip select is high, SCLK is low, and `done_o`, `err_o`, `err_code_o` and `byte_vld_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; SCLK runs at half this rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| reload_n_i | input | 1 | Restart request; a falling edge starts a new load |
| fast_i | input | 1 | Selects the fast-read opcode with a dummy byte |
| start_addr_i | input | 24 | Flash address of the first image to try |
| spi_miso_i | input | 1 | Serial data from the flash |
| spi_sclk_o | output | 1 | Serial clock |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| byte_o | output | 8 | Payload byte for the configuration sink |
| byte_vld_o | output | 1 | High for one cycle per payload byte |
| ready_o | output | 1 | High when no load is in progress |
| done_o | output | 1 | A load has finished |
| err_o | output | 1 | The finished load used the internal image |
| err_code_o | output | 2 | Cause of the last rejection |
| img_idx_o | output | 2 | Index of the attempt in use; `MAX_TRY` means internal |

## Verification
The assertions assume that `reload_n_i` is synchronous to `clk`. They also assume that MISO is stable around every rising SCLK edge and changes only after a falling edge.

The bench drives the reload pulse and the mode inputs on falling clock edges. It changes `fast_i` and `start_addr_i` only while a load is not being started. Its flash model updates MISO on falling SCLK edges and samples MOSI on rising edges, so all bus timing stays inside these assumptions.

// File: rtl/fbl_pkg.sv
package fbl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_GAP, ST_CMD, ST_ADDR, ST_DUMMY, ST_HDR, ST_PAY, ST_INT
   } fbl_state_e;

   typedef enum logic [1:0] {
      REJ_NONE = 2'd0,
      REJ_ID   = 2'd1,
      REJ_HDR  = 2'd2
   } fbl_rej_e;

   localparam logic [7:0] OP_READ = 8'h03;
   localparam logic [7:0] OP_FAST = 8'h0B;
   localparam int         TAIL_BYTES = 5;
endpackage

// File: rtl/fbl_spi_byte.sv
module fbl_spi_byte #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort_i,
   input  logic          go_i,
   input  logic [DW-1:0] tx_i,
   input  logic          miso_i,
   output logic          sclk_o,
   output logic          mosi_o,
   output logic          done_o,
   output logic [DW-1:0] rx_o
);
   localparam int CW = $clog2(DW);
   localparam logic [CW-1:0] LAST = CW'(DW - 1);

   logic          busy, sclk_q, done_q;
   logic [CW-1:0] bit_q;
   logic [DW-1:0] tx_sh, rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
         bit_q  <= '0;
         tx_sh  <= '0;
         rx_sh  <= '0;
      end else begin
         done_q <= 1'b0;
         if (abort_i) begin
            busy   <= 1'b0;
            sclk_q <= 1'b0;
            bit_q  <= '0;
         end else if (!busy) begin
            if (go_i) begin
               busy  <= 1'b1;
               tx_sh <= tx_i;
               bit_q <= '0;
            end
         end else if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_sh  <= {rx_sh[DW-2:0], miso_i};
         end else begin
            sclk_q <= 1'b0;
            if (bit_q == LAST) begin
               busy   <= 1'b0;
               done_q <= 1'b1;
            end else begin
               bit_q <= bit_q + 1'b1;
               tx_sh <= {tx_sh[DW-2:0], 1'b0};
            end
         end
      end
   end

   assign sclk_o = sclk_q;
   assign mosi_o = tx_sh[DW-1];
   assign done_o = done_q;
   assign rx_o   = rx_sh;
endmodule

// File: rtl/fbl_golden_src.sv
module fbl_golden_src #(
   parameter logic [7:0] SEED  = 8'hA5,
   parameter int         CNT_W = 4
) (
   input  logic [CNT_W-1:0] idx_i,
   output logic [7:0]       byte_o
);
   logic [7:0] idx8;
   generate
      if (CNT_W >= 8) begin : g_wide
         assign idx8 = idx_i[7:0];
      end else begin : g_narrow
         assign idx8 = {{(8 - CNT_W){1'b0}}, idx_i};
      end
   endgenerate
   assign byte_o = SEED + idx8;
endmodule

// File: rtl/flash_boot_loader.sv
module flash_boot_loader
   import fbl_pkg::*;
#(
   parameter logic [31:0] DEV_ID      = 32'h1A2B3C4D,
   parameter logic [7:0]  HDR_CODE    = 8'hC3,
   parameter int          ADDR_W      = 24,
   parameter int          PAYLOAD_LEN = 4,
   parameter int          MAX_TRY     = 3,
   parameter int          GAP_CYC     = 4,
   parameter logic [7:0]  INT_SEED    = 8'hA5,
   localparam int         IDX_W       = $clog2(MAX_TRY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload_n_i,
   input  logic              fast_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              spi_miso_i,
   output logic              spi_sclk_o,
   output logic              spi_cs_n_o,
   output logic              spi_mosi_o,
   output logic [7:0]        byte_o,
   output logic              byte_vld_o,
   output logic              ready_o,
   output logic              done_o,
   output logic              err_o,
   output logic [1:0]        err_code_o,
   output logic [IDX_W-1:0]  img_idx_o
);
   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam int HDR_BYTES  = ADDR_BYTES + TAIL_BYTES;
   localparam int HDR_W      = HDR_BYTES * 8;
   localparam int CNT_W      = $clog2(PAYLOAD_LEN + GAP_CYC + HDR_BYTES + 1);
   localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BYTES - 1);
   localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BYTES - 1);
   localparam logic [CNT_W-1:0] PAY_LAST  = CNT_W'(PAYLOAD_LEN - 1);
   localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(MAX_TRY - 1);

   initial begin
      if (ADDR_W < 8 || ADDR_W % 8 != 0) $error("ADDR_W must be a multiple of 8");
      if (MAX_TRY < 1)     $error("MAX_TRY must be at least 1");
      if (PAYLOAD_LEN < 1) $error("PAYLOAD_LEN must be at least 1");
      if (GAP_CYC < 2)     $error("GAP_CYC must be at least 2");
   end

   fbl_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] cur_addr, addr_sh, nxt_addr;
   logic              fast_q, reload_q, boot_q, pend, cs_n_q;
   logic              done_q, err_q, vld_q;
   logic [1:0]        code_q;
   logic [IDX_W-1:0]  idx_q;
   logic [7:0]        byte_q, eng_tx, eng_rx, gold_byte;
   logic [HDR_W-1:0]  hdr_q, hdr_nx;
   logic              start, spi_phase, eng_go, eng_done, id_ok, code_ok;

   assign start     = boot_q | (reload_q & ~reload_n_i);
   assign spi_phase = (st == ST_CMD) || (st == ST_ADDR) || (st == ST_DUMMY) ||
                      (st == ST_HDR) || (st == ST_PAY);
   assign eng_go    = spi_phase & ~pend;
   assign addr_sh   = cur_addr >> (8 * (ADDR_BYTES - 1 - int'(cnt)));
   assign hdr_nx    = {hdr_q[HDR_W-9:0], eng_rx};
   assign nxt_addr  = hdr_nx[HDR_W-1 -: ADDR_W];
   assign id_ok     = (hdr_nx[39:8] == DEV_ID);
   assign code_ok   = (hdr_nx[7:0] == HDR_CODE);

   always_comb begin
      case (st)
         ST_CMD:  eng_tx = fast_q ? OP_FAST : OP_READ;
         ST_ADDR: eng_tx = addr_sh[7:0];
         default: eng_tx = 8'h00;
      endcase
   end

   fbl_spi_byte #(.DW(8)) u_spi (
      .clk(clk), .rst_n(rst_n), .abort_i(start), .go_i(eng_go), .tx_i(eng_tx),
      .miso_i(spi_miso_i), .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o),
      .done_o(eng_done), .rx_o(eng_rx)
   );

   fbl_golden_src #(.SEED(INT_SEED), .CNT_W(CNT_W)) u_gold (
      .idx_i(cnt), .byte_o(gold_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         cur_addr <= '0;
         fast_q   <= 1'b0;
         reload_q <= 1'b1;
         boot_q   <= 1'b1;
         pend     <= 1'b0;
         cs_n_q   <= 1'b1;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         vld_q    <= 1'b0;
         code_q   <= REJ_NONE;
         idx_q    <= '0;
         byte_q   <= '0;
         hdr_q    <= '0;
      end else begin
         reload_q <= reload_n_i;
         boot_q   <= 1'b0;
         vld_q    <= 1'b0;
         if (eng_go) pend <= 1'b1;
         else if (eng_done) pend <= 1'b0;
         if (start) begin
            st       <= ST_GAP;
            cnt      <= '0;
            cs_n_q   <= 1'b1;
            cur_addr <= start_addr_i;
            fast_q   <= fast_i;
            idx_q    <= '0;
            code_q   <= REJ_NONE;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            pend     <= 1'b0;
         end else begin
            case (st)
               ST_GAP: begin
                  if (cnt == GAP_LAST) begin
                     st     <= ST_CMD;
                     cnt    <= '0;
                     cs_n_q <= 1'b0;
                  end else cnt <= cnt + 1'b1;
               end
               ST_CMD: if (eng_done) st <= ST_ADDR;
               ST_ADDR: if (eng_done) begin
                  if (cnt == ADDR_LAST) begin
                     cnt <= '0;
                     st  <= fast_q ? ST_DUMMY : ST_HDR;
                  end else cnt <= cnt + 1'b1;
               end
               ST_DUMMY: if (eng_done) st <= ST_HDR;
               ST_HDR: if (eng_done) begin
                  hdr_q <= hdr_nx;
                  if (cnt == HDR_LAST) begin
                     cnt <= '0;
                     if (id_ok && code_ok) st <= ST_PAY;
                     else begin
                        code_q <= id_ok ? REJ_HDR : REJ_ID;
                        cs_n_q <= 1'b1;
                        idx_q  <= idx_q + 1'b1;
                        if (idx_q == IDX_LAST) st <= ST_INT;
                        else begin
                           st       <= ST_GAP;
                           cur_addr <= nxt_addr;
                        end
                     end
                  end else cnt <= cnt + 1'b1;
               end
               ST_PAY: if (eng_done) begin
                  byte_q <= eng_rx;
                  vld_q  <= 1'b1;
                  if (cnt == PAY_LAST) begin
                     st     <= ST_IDLE;
                     cnt    <= '0;
                     cs_n_q <= 1'b1;
                     done_q <= 1'b1;
                  end else cnt <= cnt + 1'b1;
               end
               ST_INT: begin
                  byte_q <= gold_byte;
                  vld_q  <= 1'b1;
                  if (cnt == PAY_LAST) begin
                     st     <= ST_IDLE;
                     cnt    <= '0;
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end else cnt <= cnt + 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign spi_cs_n_o = cs_n_q;
   assign byte_o     = byte_q;
   assign byte_vld_o = vld_q;
   assign ready_o    = (st == ST_IDLE) & ~boot_q;
   assign done_o     = done_q;
   assign err_o      = err_q;
   assign err_code_o = code_q;
   assign img_idx_o  = idx_q;
endmodule

// File: rtl/fbl_checker.sv
module fbl_checker #(
   parameter int MAX_TRY = 3,
   parameter int IDX_W   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reload_n_i,
   input logic             spi_sclk_o,
   input logic             spi_cs_n_o,
   input logic             byte_vld_o,
   input logic             ready_o,
   input logic             done_o,
   input logic             err_o,
   input logic [1:0]       err_code_o,
   input logic [IDX_W-1:0] img_idx_o
);
   AST_CS_LOW_WITH_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk_o |-> !spi_cs_n_o); // R2
   AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (spi_cs_n_o && !spi_sclk_o)); // R9
   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      err_code_o != 2'd3); // R4
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(img_idx_o) |-> (img_idx_o == $past(img_idx_o) + 1'b1 || img_idx_o == '0)); // R5
   AST_FALLBACK_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (img_idx_o == IDX_W'(MAX_TRY))); // R6
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o); // R7
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && reload_n_i) |=> done_o); // R7
   AST_VLD_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |-> !$past(ready_o)); // R3
endmodule

bind flash_boot_loader fbl_checker #(.MAX_TRY(MAX_TRY), .IDX_W(IDX_W)) u_fbl_chk (
   .clk(clk), .rst_n(rst_n), .reload_n_i(reload_n_i), .spi_sclk_o(spi_sclk_o),
   .spi_cs_n_o(spi_cs_n_o), .byte_vld_o(byte_vld_o), .ready_o(ready_o),
   .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o), .img_idx_o(img_idx_o)
);

// File: tb/tb_flash_boot_loader.sv
`timescale 1ns/1ps
module tb_flash_boot_loader;
   localparam logic [31:0] DEV_ID   = 32'h1A2B3C4D;
   localparam logic [31:0] BAD_ID   = 32'h1A2B3C4E;
   localparam logic [7:0]  HDR_CODE = 8'hC3;
   localparam int          PL       = 4;
   localparam int          MAXT     = 3;
   localparam logic [7:0]  INT_SEED = 8'hA5;
   // {fast, start[7:0], idx[1:0], code[1:0], err, seed[7:0], transactions[1:0]}
   localparam logic [23:0] VEC [0:6] = '{
      {1'b0, 8'h00, 2'd0, 2'd0, 1'b0, 8'h10, 2'd1},
      {1'b1, 8'h00, 2'd0, 2'd0, 1'b0, 8'h10, 2'd1},
      {1'b0, 8'h40, 2'd2, 2'd2, 1'b0, 8'h70, 2'd3},
      {1'b1, 8'h80, 2'd1, 2'd2, 1'b0, 8'h70, 2'd2},
      {1'b0, 8'h20, 2'd3, 2'd2, 1'b1, 8'hA5, 2'd3},
      {1'b1, 8'hE0, 2'd1, 2'd1, 1'b0, 8'h70, 2'd2},
      {1'b1, 8'h60, 2'd2, 2'd2, 1'b0, 8'h10, 2'd3}
   };

   logic clk = 1'b0, rst_n = 1'b0, reload_n = 1'b1, fast = 1'b0, spi_miso = 1'b0;
   logic [23:0] start_addr = 24'h0;
   logic spi_sclk, spi_cs_n, spi_mosi, byte_vld, ready, done, err;
   logic [7:0] byte_d;
   logic [1:0] err_code, img_idx;

   int checks = 0, fails = 0;
   logic [7:0] mem [0:255];
   logic [7:0] cap [0:15];
   int ncap = 0;
   int bc = 0, ntrans = 0, hb, kk;
   logic [7:0] op = 8'h0, lop = 8'h0;
   logic [23:0] ad = 24'h0, fad = 24'h0;

   always #2 clk = ~clk;

   flash_boot_loader #(.DEV_ID(DEV_ID), .HDR_CODE(HDR_CODE), .ADDR_W(24),
      .PAYLOAD_LEN(PL), .MAX_TRY(MAXT), .GAP_CYC(4), .INT_SEED(INT_SEED)) dut (
      .clk(clk), .rst_n(rst_n), .reload_n_i(reload_n), .fast_i(fast),
      .start_addr_i(start_addr), .spi_miso_i(spi_miso), .spi_sclk_o(spi_sclk),
      .spi_cs_n_o(spi_cs_n), .spi_mosi_o(spi_mosi), .byte_o(byte_d),
      .byte_vld_o(byte_vld), .ready_o(ready), .done_o(done), .err_o(err),
      .err_code_o(err_code), .img_idx_o(img_idx)
   );

   // flash model
   always @(negedge spi_cs_n) begin
      bc = 0;
      ntrans = ntrans + 1;
   end
   always @(posedge spi_sclk) if (spi_cs_n === 1'b0) begin
      if (bc < 8) op = {op[6:0], spi_mosi};
      else if (bc < 32) ad = {ad[22:0], spi_mosi};
      bc = bc + 1;
      if (bc == 32) begin
         lop = op;
         if (ntrans == 1) fad = ad;
      end
   end
   always @(negedge spi_sclk) if (spi_cs_n === 1'b0) begin
      hb = (op == 8'h0B) ? 40 : 32;
      if (bc >= hb) begin
         kk = bc - hb;
         spi_miso = mem[(int'(ad[7:0]) + kk / 8) % 256][7 - kk % 8];
      end
   end
   always @(negedge clk) if (byte_vld === 1'b1 && ncap < 16) begin
      cap[ncap] = byte_d;
      ncap = ncap + 1;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic put_img(input int b, input logic [7:0] nxt, input logic [31:0] id,
                          input logic [7:0] code, input logic [7:0] seed);
      mem[b] = 8'h00; mem[b+1] = 8'h00; mem[b+2] = nxt;
      mem[b+3] = id[31:24]; mem[b+4] = id[23:16]; mem[b+5] = id[15:8]; mem[b+6] = id[7:0];
      mem[b+7] = code;
      for (int k = 0; k < PL; k++) mem[b+8+k] = seed + 8'(k);
   endtask

   task automatic pulse_reload(input logic f, input logic [7:0] a);
      fast = f;
      start_addr = {16'h0, a};
      ntrans = 0;
      ncap = 0;
      @(negedge clk) reload_n = 1'b0;
      @(negedge clk) reload_n = 1'b1;
   endtask

   task automatic wait_done();
      int t = 0;
      repeat (2) @(negedge clk);
      while (done !== 1'b1 && t < 6000) begin
         @(negedge clk);
         t++;
      end
      @(negedge clk);
   endtask

   task automatic check_load(input logic f, input logic [7:0] a, input int idx,
                             input int code, input int e, input logic [7:0] seed, input int ntr);
      chk("R7", "done", int'(done), 1);
      chk("R9", "ready after load", int'(ready), 1);
      chk("R1", "opcode", int'(lop), f ? 8'h0B : 8'h03);
      chk("R1", "first address", int'(fad), int'(a));
      chk("R5", "image index", int'(img_idx), idx);
      chk("R4", "reject code", int'(err_code), code);
      chk("R6", "fallback flag", int'(err), e);
      chk("R5", "transactions", ntrans, ntr);
      chk("R3", "byte count", ncap, PL);
      for (int k = 0; k < PL; k++)
         chk(e ? "R6" : "R3", "payload byte", int'(cap[k]), int'(seed + 8'(k)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      put_img(8'h00, 8'h00, DEV_ID, HDR_CODE, 8'h10);
      put_img(8'h20, 8'h60, BAD_ID, HDR_CODE, 8'h50);
      put_img(8'h40, 8'h80, BAD_ID, HDR_CODE, 8'h30);
      put_img(8'h60, 8'hA0, BAD_ID, HDR_CODE, 8'h90);
      put_img(8'h80, 8'hC0, DEV_ID, 8'h00, 8'h20);
      put_img(8'hA0, 8'h00, DEV_ID, 8'h00, 8'h40);
      put_img(8'hC0, 8'h00, DEV_ID, HDR_CODE, 8'h70);
      put_img(8'hE0, 8'hC0, BAD_ID, 8'h00, 8'h60);

      repeat (3) @(negedge clk);
      chk("R10", "cs_n in reset", int'(spi_cs_n), 1);
      chk("R10", "sclk in reset", int'(spi_sclk), 0);
      chk("R10", "done in reset", int'(done), 0);
      chk("R10", "err in reset", int'(err), 0);
      chk("R10", "code in reset", int'(err_code), 0);
      chk("R10", "valid in reset", int'(byte_vld), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R9", "ready during boot load", int'(ready), 0);
      wait_done();
      check_load(1'b0, 8'h00, 0, 0, 0, 8'h10, 1);

      for (int v = 0; v < 7; v++) begin
         pulse_reload(VEC[v][23], VEC[v][22:15]);
         @(negedge clk);
         chk("R8", "done cleared by restart", int'(done), 0);
         wait_done();
         check_load(VEC[v][23], VEC[v][22:15], int'(VEC[v][14:13]), int'(VEC[v][12:11]),
                    int'(VEC[v][10]), VEC[v][9:2], int'(VEC[v][1:0]));
      end

      // R8: restart in the middle of a chained load
      pulse_reload(1'b0, 8'h40);
      repeat (300) @(negedge clk);
      chk("R9", "ready mid load", int'(ready), 0);
      chk("R8", "not done mid load", int'(done), 0);
      pulse_reload(1'b1, 8'h00);
      wait_done();
      check_load(1'b1, 8'h00, 0, 0, 0, 8'h10, 1);
      chk("R9", "cs_n idle", int'(spi_cs_n), 1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule